// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block is the device-side logic of a serial flash that understands four single-line instructions: set write enable, erase the whole array, erase one sector, and read the status byte. A host frames each instruction by pulling chip select low and clocking bits into the data input, most significant bit first, on rising edges of the serial clock. When chip select rises, the block decides from the opcode, the exact number of bits received, the write-enable latch and the block-protect inputs whether an erase is committed.

A committed erase starts a self-timed busy cycle of `ERASE_CYCLES` system clocks, counted from the clock edge that sees chip select rise. While the busy cycle runs, the write-in-progress flag reads 1 and only status reads are answered. At the end of the cycle the affected bytes of a small behavioural array become FFh. A read port on the array lets the surrounding model or bench inspect its contents. The serial clock and chip select are assumed synchronous to the system clock and are oversampled. Each serial clock phase must last at least two system clocks.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, the status byte reads 00h, and array byte i holds the value i modulo 256.
- R2: The instruction 06h, framed with exactly 8 bits, sets the write-enable latch. That latch is status bit 1.
- R3: An instruction runs only when chip select rises after exactly the required number of bits: 8 for 06h and C7h, and 32 for D8h. Any other count discards the frame and leaves the write-enable latch unchanged.
- R4: The instruction C7h, accepted with the latch set and all protect bits 0, turns every array byte into FFh once the busy cycle ends.
- R5: The instruction D8h carries a 24-bit address after the opcode, sent most significant bit first. Accepted with the latch set and all protect bits 0, it erases to FFh only the sector that holds the address. The sector index is the address taken modulo the array size, divided by the sector size. All other bytes are left alone.
- R6: An erase instruction that arrives while the write-enable latch is clear is ignored.
- R7: If any block-protect input bit is 1, both erase instructions are ignored and the latch keeps its value.
- R8: The write-in-progress flag is status bit 0. It rises on the clock edge that detects chip select going high after an accepted erase, and it stays 1 for exactly `ERASE_CYCLES` clocks.
- R9: The write-enable latch clears when an erase is accepted, so it reads 0 throughout the busy cycle.
- R10: While the busy flag is 1, every instruction except 05h is ignored. A write enable does not set the latch, and a second erase does not run.
- R11: After the opcode 05h, each falling serial clock edge shifts one status bit out on `miso`, MSB first. The byte is {6'b0, latch, busy}, and it repeats for as long as chip select stays low. When chip select is high, `miso` is 0.
- R12: The array contents do not change during the busy cycle. The erase lands on the clock edge where the busy flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; frames one instruction |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block, sampled on rising `sck` |
| miso | output | 1 | Serial status data out, updated after falling `sck` |
| bp | input | BP_BITS | Block-protect bits; any 1 blocks erasure |
| rd_addr | input | clog2(MEM_BYTES) | Byte address for inspecting the array |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bench builds the block with a 64-byte array split into four 16-byte sectors, four protect bits and a 600-clock busy cycle. At this size every byte can be compared with a model after each step. Each sector index can be erased in turn, with different upper address bits that must be discarded. All fifteen nonzero protect patterns can be swept. The busy cycle is long enough for a status poll and a rejected instruction to fit inside it, and the bench pins the exact clock edge where the erase lands. The framing sweep tries every bit count from 1 to 12 for the bulk opcode and from 8 to 40 for the sector opcode.

// File: rtl/flash_erase_pkg.sv
// Shared opcodes, framing constants and the erase-kind type for the
// erase sequencer. Pure declarations; no logic.
package flash_erase_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_BULK  = 8'hC7;
    localparam logic [7:0] OP_SECT  = 8'hD8;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    localparam int CMD_BITS   = 8;
    localparam int FRAME_BITS = 32;
    localparam int BIT_W      = 6;

    typedef enum logic [1:0] {
        ERASE_NONE = 2'd0,
        ERASE_BULK = 2'd1,
        ERASE_SECT = 2'd2
    } erase_kind_e;

endpackage

// File: rtl/flash_frame_rx.sv
// Frame receiver. Oversamples cs_n and sck with the system clock and
// captures the opcode and the sector-index bits of the address on rising
// sck while cs_n is low. It also keeps a saturating bit count.
// Assumes: sck and cs_n are synchronous to clk, and each sck phase lasts
// at least two clk periods. Only the address bits that select a sector
// are kept; the higher bits wrap away.
module flash_frame_rx
    import flash_erase_pkg::*;
#(
    parameter int SECT_LSB = 4,
    parameter int SECT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              sck_fall,
    output logic              frame_end,
    output logic [7:0]        cmd,
    output logic [BIT_W-1:0]  bits,
    output logic [SECT_W-1:0] sect
);

    localparam logic [BIT_W-1:0] CMD_DONE  = BIT_W'(CMD_BITS);
    localparam logic [BIT_W-1:0] SECT_STOP = BIT_W'(FRAME_BITS - SECT_LSB);

    logic sck_q;
    logic cs_q;
    logic sck_rise;
    logic cs_fall;

    // Edge detection on the oversampled serial lines.
    always_comb begin
        sck_rise  = !cs_n && sck && !sck_q;
        sck_fall  = !cs_n && !sck && sck_q;
        cs_fall   = !cs_n && cs_q;
        frame_end = cs_n && !cs_q;
    end

    // Previous-sample registers for the edge detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Bit capture: the opcode first, then the sector-select address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
            cmd  <= '0;
            sect <= '0;
        end else if (cs_fall) begin
            bits <= '0;
            cmd  <= '0;
            sect <= '0;
        end else if (sck_rise) begin
            if (bits != '1) begin
                bits <= bits + 1'b1;
            end
            if (bits < CMD_DONE) begin
                cmd <= {cmd[6:0], mosi};
            end else if (bits < SECT_STOP) begin
                sect <= SECT_W'({sect, mosi});
            end
        end
    end

endmodule

// File: rtl/flash_status_tx.sv
// Status shifter. Once the opcode of the current frame has been read as
// the status-read code, it drives one status bit per falling sck, MSB
// first. A snapshot of the status byte is taken at the start of each
// byte, so every byte is consistent within itself.
// Assumes: cmd and bits come from the frame receiver of the same frame.
module flash_status_tx
    import flash_erase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck_fall,
    input  logic [7:0]       cmd,
    input  logic [BIT_W-1:0] bits,
    input  logic [7:0]       status,
    output logic             miso
);

    logic       rd_active;
    logic [2:0] idx;
    logic [7:0] snap;

    // Status output is enabled after a complete read-status opcode.
    always_comb begin
        rd_active = (bits >= BIT_W'(CMD_BITS)) && (cmd == OP_RDSR);
    end

    // Shift register: snapshot at byte start, then one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso <= 1'b0;
            idx  <= '0;
            snap <= '0;
        end else if (cs_n) begin
            miso <= 1'b0;
            idx  <= '0;
        end else if (sck_fall && rd_active) begin
            if (idx == 3'd0) begin
                miso <= status[7];
                snap <= status;
            end else begin
                miso <= snap[3'd7 - idx];
            end
            idx <= idx + 3'd1;
        end
    end

endmodule

// File: rtl/flash_erase_ctrl.sv
// Erase controller. It decodes a finished frame on the rising edge of
// chip select and holds the write-enable latch. It runs the self-timed
// busy counter and signals the array on the edge where the busy cycle ends.
// Assumes: ERASE_CYCLES >= 1; frame fields are stable while frame_end is high.
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int ERASE_CYCLES = 1000,
    parameter int BP_BITS      = 4,
    parameter int SECT_W       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end,
    input  logic [7:0]         cmd,
    input  logic [BIT_W-1:0]   bits,
    input  logic [SECT_W-1:0]  sect_in,
    input  logic [BP_BITS-1:0] bp,
    output logic               wip,
    output logic               wel,
    output logic               erase_fire,
    output erase_kind_e        erase_kind,
    output logic [SECT_W-1:0]  erase_sect
);

    localparam int CW = $clog2(ERASE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(ERASE_CYCLES - 1);

    logic          is_wren;
    logic          is_bulk;
    logic          is_sect;
    logic          unlocked;
    logic          accept;
    logic [CW-1:0] remain;

    // Frame decoding: opcode, exact bit count, latch and protect gating.
    always_comb begin
        is_wren    = (bits == BIT_W'(CMD_BITS))   && (cmd == OP_WREN);
        is_bulk    = (bits == BIT_W'(CMD_BITS))   && (cmd == OP_BULK);
        is_sect    = (bits == BIT_W'(FRAME_BITS)) && (cmd == OP_SECT);
        unlocked   = (bp == '0);
        accept     = frame_end && !wip && wel && unlocked && (is_bulk || is_sect);
        erase_fire = wip && (remain == '0);
    end

    // Write-enable latch: set by a write enable, cleared when an erase is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (accept) begin
            wel <= 1'b0;
        end else if (frame_end && !wip && is_wren) begin
            wel <= 1'b1;
        end
    end

    // Busy timer: load on accept, count down, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip    <= 1'b0;
            remain <= '0;
        end else if (accept) begin
            wip    <= 1'b1;
            remain <= LOAD;
        end else if (wip) begin
            if (remain == '0) begin
                wip <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    // Erase target: latched at accept and held through the busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_kind <= ERASE_NONE;
            erase_sect <= '0;
        end else if (accept) begin
            erase_kind <= is_bulk ? ERASE_BULK : ERASE_SECT;
            erase_sect <= sect_in;
        end
    end

endmodule

// File: rtl/flash_erase_array.sv
// Behavioural byte array. Reset loads byte i with i mod 256. A fire pulse
// sets either every byte or the bytes of one sector to FFh. Reads are
// combinational.
// Assumes: MEM_BYTES and SECTOR_BYTES are powers of two, with at least
// two sectors.
module flash_erase_array
    import flash_erase_pkg::*;
#(
    parameter int MEM_BYTES    = 64,
    parameter int SECTOR_BYTES = 16,
    localparam int AW          = $clog2(MEM_BYTES),
    localparam int SECT_W      = $clog2(MEM_BYTES / SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_fire,
    input  erase_kind_e       erase_kind,
    input  logic [SECT_W-1:0] erase_sect,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [MEM_BYTES];

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_byte
        localparam logic [7:0]        INIT  = 8'(g % 256);
        localparam logic [SECT_W-1:0] MY_SC = SECT_W'(g / SECTOR_BYTES);
        logic hit;

        // Selection: this byte falls inside the erase target.
        always_comb begin
            hit = (erase_kind == ERASE_BULK) ||
                  ((erase_kind == ERASE_SECT) && (erase_sect == MY_SC));
        end

        // Byte storage: reset pattern, or FFh on an erase that covers this byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= INIT;
            end else if (erase_fire && hit) begin
                mem[g] <= 8'hFF;
            end
        end
    end

    // Read port for inspection.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/flash_erase_seq.sv
// Top of the erase sequencer. It wires together the frame receiver, the
// status shifter, the erase controller and the byte array.
// Assumes: serial inputs are synchronous to clk; see the frame receiver.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int MEM_BYTES    = 64,
    parameter int SECTOR_BYTES = 16,
    parameter int ERASE_CYCLES = 1000,
    parameter int BP_BITS      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sck,
    input  logic                         mosi,
    output logic                         miso,
    input  logic [BP_BITS-1:0]           bp,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data
);

    localparam int SECT_LSB = $clog2(SECTOR_BYTES);
    localparam int SECT_W   = $clog2(MEM_BYTES / SECTOR_BYTES);

    logic              sck_fall;
    logic              frame_end;
    logic [7:0]        cmd;
    logic [BIT_W-1:0]  bits;
    logic [SECT_W-1:0] sect;
    logic              wip;
    logic              wel;
    logic              erase_fire;
    erase_kind_e       erase_kind;
    logic [SECT_W-1:0] erase_sect;
    logic [7:0]        status;

    // Status byte layout: bit 1 latch, bit 0 busy.
    always_comb begin
        status = {6'b0, wel, wip};
    end

    flash_frame_rx #(
        .SECT_LSB (SECT_LSB),
        .SECT_W   (SECT_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .mosi      (mosi),
        .sck_fall  (sck_fall),
        .frame_end (frame_end),
        .cmd       (cmd),
        .bits      (bits),
        .sect      (sect)
    );

    flash_status_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck_fall (sck_fall),
        .cmd      (cmd),
        .bits     (bits),
        .status   (status),
        .miso     (miso)
    );

    flash_erase_ctrl #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .BP_BITS      (BP_BITS),
        .SECT_W       (SECT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .cmd        (cmd),
        .bits       (bits),
        .sect_in    (sect),
        .bp         (bp),
        .wip        (wip),
        .wel        (wel),
        .erase_fire (erase_fire),
        .erase_kind (erase_kind),
        .erase_sect (erase_sect)
    );

    flash_erase_array #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_fire (erase_fire),
        .erase_kind (erase_kind),
        .erase_sect (erase_sect),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/flash_erase_checker.sv
// Temporal checks on the erase sequencer, bound into every instance of
// the top module.
module flash_erase_checker #(
    parameter int ERASE_CYCLES = 1000,
    parameter int BP_BITS      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               miso,
    input logic [BP_BITS-1:0] bp,
    input logic               wip,
    input logic               wel
);

    localparam int RW = $clog2(ERASE_CYCLES + 2);

    logic [RW-1:0] run_len;

    // Busy-run length counter, used for the window check below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (wip) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    p_wip_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (run_len == RW'(ERASE_CYCLES)));

    p_wip_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RW'(ERASE_CYCLES));

    p_wip_clears_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !wel);

    p_start_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    p_start_needs_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(bp) == '0));

    p_start_on_cs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));

    p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso);

endmodule

bind flash_erase_seq flash_erase_checker #(
    .ERASE_CYCLES (ERASE_CYCLES),
    .BP_BITS      (BP_BITS)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .miso  (miso),
    .bp    (bp),
    .wip   (wip),
    .wel   (wel)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;

    localparam int MEM_BYTES    = 64;
    localparam int SECTOR_BYTES = 16;
    localparam int ERASE_CYCLES = 600;
    localparam int BP_BITS      = 4;
    localparam int HALF         = 4;
    localparam int AW           = $clog2(MEM_BYTES);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cs_n = 1'b1;
    logic               sck = 1'b0;
    logic               mosi = 1'b0;
    logic               miso;
    logic [BP_BITS-1:0] bp = '0;
    logic [AW-1:0]      rd_addr = '0;
    logic [7:0]         rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [MEM_BYTES];

    always #2 clk = ~clk;

    flash_erase_seq #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .BP_BITS      (BP_BITS)
    ) i_flash_erase_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .bp      (bp),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sends nbits of data MSB first; returns status bits seen at bit slots 8..23.
    task automatic spi_xfer(input logic [39:0] data, input int nbits, output logic [15:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            sck  = 1'b0;
            mosi = data[39-k];
            repeat (HALF) @(negedge clk);
            if (k >= 8 && k < 24) rx[23-k] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sck  = 1'b0;
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic send(input logic [39:0] data, input int nbits);
        logic [15:0] dummy;
        spi_xfer(data, nbits, dummy);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [15:0] rx;
        spi_xfer({8'h05, 32'h0}, 24, rx);
        check16(req, rx, {exp, exp});
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        logic [7:0] a_act = '0;
        logic [7:0] a_exp = '0;
        checks++;
        for (int a = 0; a < MEM_BYTES; a++) begin
            rd_addr = AW'(a);
            #0.01;
            if (rd_data !== exp_mem[a]) begin
                if (bad == 0) begin
                    a_act = rd_data;
                    a_exp = exp_mem[a];
                end
                bad++;
            end
        end
        if (bad != 0) begin
            fails++;
            $display("FAIL %s memory mismatch count=%0d first actual=%h expected=%h",
                     req, bad, a_act, a_exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < MEM_BYTES; a++) exp_mem[a] = 8'(a % 256);
    endtask

    task automatic model_sector(input int s);
        for (int a = 0; a < MEM_BYTES; a++)
            if (a / SECTOR_BYTES == s) exp_mem[a] = 8'hFF;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        model_reset();
    endtask

    task automatic wait_done();
        repeat (ERASE_CYCLES + 20) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [23:0] addr;
        do_reset();

        // R1: reset state
        read_status("R1 status after reset", 8'h00);
        check_mem("R1 reset pattern");

        // R6: erase without the latch is ignored
        send({8'hC7, 32'h0}, 8);
        send({8'hD8, 24'h000010, 8'h0}, 32);
        wait_done();
        read_status("R6 no latch, status", 8'h00);
        check_mem("R6 no latch, memory");

        // R3: a write enable with a wrong bit count is discarded
        send({8'h06, 32'h0}, 7);
        read_status("R3 wren 7 bits", 8'h00);
        send({8'h06, 32'h0}, 9);
        read_status("R3 wren 9 bits", 8'h00);

        // R2: a correct write enable sets the latch
        send({8'h06, 32'h0}, 8);
        read_status("R2 wren sets latch", 8'h02);

        // R3: framing sweep for the bulk and sector opcodes; latch must survive
        for (int n = 1; n <= 12; n++) begin
            if (n != 8) begin
                send({8'hC7, 32'h0}, n);
                read_status("R3 bulk bad count", 8'h02);
            end
        end
        for (int n = 8; n <= 40; n++) begin
            if (n != 32) begin
                send({8'hD8, 24'h000020, 8'h0}, n);
                read_status("R3 sector bad count", 8'h02);
            end
        end
        check_mem("R3 framing sweep memory");

        // R7: every nonzero protect pattern blocks both erases
        for (int b = 1; b < (1 << BP_BITS); b++) begin
            bp = BP_BITS'(b);
            send({8'hC7, 32'h0}, 8);
            send({8'hD8, 24'h000030, 8'h0}, 32);
            read_status("R7 protected, latch kept", 8'h02);
        end
        bp = '0;
        check_mem("R7 protected memory");

        // R8 R12: exact busy length, seen as the edge where sector 2 changes
        rd_addr = AW'(32);
        send({8'hD8, 24'h7A5F25, 8'h0}, 32);
        @(posedge clk);
        repeat (ERASE_CYCLES - 1) @(posedge clk);
        #1;
        check16("R12 unchanged before end", {8'h0, rd_data}, 16'h0020);
        @(posedge clk);
        #1;
        check16("R8 erased at cycle end", {8'h0, rd_data}, 16'h00FF);
        model_sector(2);
        repeat (4) @(negedge clk);
        read_status("R9 latch clear after erase", 8'h00);
        check_mem("R5 sector 2 only");

        // R8 R9 R10 R11: status poll during busy; other instructions ignored
        send({8'h06, 32'h0}, 8);
        send({8'hD8, 24'h800005, 8'h0}, 32);
        read_status("R8 busy flag, R9 latch clear, R11 repeat", 8'h01);
        send({8'h06, 32'h0}, 8);
        send({8'hC7, 32'h0}, 8);
        read_status("R10 wren ignored while busy", 8'h01);
        check_mem("R12 memory held while busy");
        wait_done();
        model_sector(0);
        read_status("R10 latch still clear after busy", 8'h00);
        check_mem("R10 second erase not run, R5 sector 0");

        // R4: bulk erase clears every byte
        send({8'h06, 32'h0}, 8);
        send({8'hC7, 32'h0}, 8);
        read_status("R4 bulk busy", 8'h01);
        wait_done();
        for (int a = 0; a < MEM_BYTES; a++) exp_mem[a] = 8'hFF;
        check_mem("R4 bulk memory");
        read_status("R4 bulk done status", 8'h00);

        // R5: every sector index, with varied upper address bits
        do_reset();
        check_mem("R1 reset pattern again");
        for (int s = 0; s < MEM_BYTES / SECTOR_BYTES; s++) begin
            addr = (24'hC3_96_00 + 24'(s * 24'h0111C0)) & ~24'(MEM_BYTES - SECTOR_BYTES);
            addr = addr | 24'(s * SECTOR_BYTES) | 24'(s % SECTOR_BYTES);
            send({8'h06, 32'h0}, 8);
            send({8'hD8, addr, 8'h0}, 32);
            wait_done();
            model_sector(s);
            check_mem("R5 sector sweep");
        end

        finish_run();
    end

endmodule